// File: doc/BRIEF.md
# Card Host Interrupt Aggregator

This block gathers the one-cycle event pulses raised by a memory-card host controller's command engine, data engine, FIFO and card-presence logic. Each pulse sets a sticky flag in a raw event register. Software reads that register to see every pending event, including events it has chosen not to be interrupted by. It clears flags by writing ones to them.

A per-flag enable mask and one global enable decide which pending flags drive a single registered interrupt line. The block also gives four summary flags that group pending events into command failures, data failures, read completion and write completion. A driver uses these to decide between waking a command waiter, waking a transfer waiter and resetting the data path.

Access is through a small word-addressed register port: a control word, the mask, a read-only view of the masked flags, and the raw flags.

Top module: `irq_hub`

## Requirements
- R1: After reset the raw flags, the mask, the global enable, the read data and the interrupt line are all zero.
- R2: A pulse on event input bit i sets raw flag i at the next clock edge. The raw flags read at word address 3 with all bits above 19 as zero. The fixed positions are: 0 card presence change, 1 response error, 2 command complete, 3 transfer finished, 4 transmit FIFO request, 5 receive FIFO request, 6 response CRC failure, 7 data CRC failure, 8 response timeout, 9 read data timeout, 10 host starvation timeout, 11 FIFO overrun or underrun, 12 locked-while-error, 13 start-bit failure, 14 automatic stop complete, 15 end-bit failure, 19:16 four card-interrupt flags.
- R3: A write to word address 3 clears each raw flag whose data bit is one and leaves flags whose data bit is zero. A write of all ones clears every flag.
- R4: When an event pulse and a clearing write hit the same flag in the same cycle, the flag ends up set.
- R5: The mask is read and written at word address 1, and bits above 19 read as zero. Word address 2 reads the raw flags ANDed with the mask, and writes to it have no effect.
- R6: The control word is at word address 0. Only bit 4 is stored; it is the global enable, and every other bit reads zero. The interrupt line is high one cycle after a cycle in which the global enable is set and at least one masked flag is pending, and low one cycle after a cycle in which either condition is false.
- R7: An event whose mask bit is zero is still recorded in the raw flags. It leaves the interrupt line low.
- R8: The group outputs are high when any pending raw flag falls in their set: command failure = bits 1, 6, 8, 12 (0x1142); data failure = bits 7, 9, 11, 12, 13, 15 (0xBA80); read end = bits 3, 5, 10 (0x428); write end = bits 3, 4, 10 (0x418).
- R9: Read data is registered. It shows the register addressed in one cycle, with that cycle's contents, after the next clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_addr | input | ADDR_W (2) | Word address of the register accessed |
| reg_wr | input | 1 | Write strobe for the addressed register |
| reg_wdata | input | DATA_W (32) | Write data |
| reg_rdata | output | DATA_W (32) | Registered read data |
| evt | input | 16+NUM_CARD_IRQ (20) | One-cycle event pulses, one per flag |
| irq | output | 1 | Registered interrupt line |
| grp_cmd_err | output | 1 | A command-failure flag is pending |
| grp_dat_err | output | 1 | A data-failure flag is pending |
| grp_rd_end | output | 1 | A read-completion flag is pending |
| grp_wr_end | output | 1 | A write-completion flag is pending |

## Verification
The checker watches every cycle. It confirms that a pulsed flag is set at the next edge even when a clearing write hits it in the same cycle, that a write clears the flags it names unless an event hits them, and that the interrupt line never rises without the global enable. The bench's sweeps are needed for the rest: the fixed position of every flag, the membership of each group, the read-back values of each address, the zeroed upper bits, and the exact one-cycle lag of the interrupt line after the mask or enable changes.

// File: rtl/irq_pkg.sv
package irq_pkg;
  localparam int NUM_CORE_EVT = 16;

  // flag positions that neighbouring logic decodes
  localparam int EV_CARD_CHG   = 0;
  localparam int EV_RSP_ERR    = 1;
  localparam int EV_CMD_DONE   = 2;
  localparam int EV_XFER_END   = 3;
  localparam int EV_TX_REQ     = 4;
  localparam int EV_RX_REQ     = 5;
  localparam int EV_RSP_CRC    = 6;
  localparam int EV_DAT_CRC    = 7;
  localparam int EV_RSP_TMO    = 8;
  localparam int EV_RD_TMO     = 9;
  localparam int EV_STARVE_TMO = 10;
  localparam int EV_FIFO_RUN   = 11;
  localparam int EV_LOCK_ERR   = 12;
  localparam int EV_START_BIT  = 13;
  localparam int EV_AUTO_STOP  = 14;
  localparam int EV_END_BIT    = 15;

  localparam logic [NUM_CORE_EVT-1:0] GRP_CMD_ERR =
    NUM_CORE_EVT'((1 << EV_RSP_ERR) | (1 << EV_RSP_CRC) | (1 << EV_RSP_TMO) | (1 << EV_LOCK_ERR));
  localparam logic [NUM_CORE_EVT-1:0] GRP_DAT_ERR =
    NUM_CORE_EVT'((1 << EV_DAT_CRC) | (1 << EV_RD_TMO) | (1 << EV_FIFO_RUN) |
                  (1 << EV_LOCK_ERR) | (1 << EV_START_BIT) | (1 << EV_END_BIT));
  localparam logic [NUM_CORE_EVT-1:0] GRP_RD_END =
    NUM_CORE_EVT'((1 << EV_XFER_END) | (1 << EV_RX_REQ) | (1 << EV_STARVE_TMO));
  localparam logic [NUM_CORE_EVT-1:0] GRP_WR_END =
    NUM_CORE_EVT'((1 << EV_XFER_END) | (1 << EV_TX_REQ) | (1 << EV_STARVE_TMO));

  // register word addresses
  localparam int ADR_CTRL   = 0;
  localparam int ADR_MASK   = 1;
  localparam int ADR_MASKED = 2;
  localparam int ADR_RAW    = 3;

  localparam int CTRL_EN_BIT = 4;
endpackage

// File: rtl/irq_raw_status.sv
module irq_raw_status #(
  parameter int W = 20
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] set_i,
  input  logic [W-1:0] clr_i,
  output logic [W-1:0] flags_o
);
  logic [W-1:0] q;

  for (genvar i = 0; i < W; i++) begin : g_flag
    always_ff @(posedge clk) begin
      if (rst)           q[i] <= 1'b0;
      else if (set_i[i]) q[i] <= 1'b1;   // a new event beats a same-cycle clear
      else if (clr_i[i]) q[i] <= 1'b0;
    end
  end

  assign flags_o = q;
endmodule

// File: rtl/irq_gate.sv
module irq_gate #(
  parameter int W = 20
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] flags_i,
  input  logic [W-1:0] mask_i,
  input  logic         en_i,
  output logic [W-1:0] masked_o,
  output logic         irq_o
);
  logic irq_q;

  assign masked_o = flags_i & mask_i;

  always_ff @(posedge clk) begin
    if (rst) irq_q <= 1'b0;
    else     irq_q <= en_i & (|masked_o);
  end

  assign irq_o = irq_q;
endmodule

// File: rtl/irq_regfile.sv
module irq_regfile
  import irq_pkg::*;
#(
  parameter int W      = 20,
  parameter int DATA_W = 32,
  parameter int ADDR_W = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic              reg_wr,
  input  logic [DATA_W-1:0] reg_wdata,
  output logic [DATA_W-1:0] reg_rdata,
  input  logic [W-1:0]      flags_i,
  input  logic [W-1:0]      masked_i,
  output logic [W-1:0]      mask_o,
  output logic              en_o,
  output logic [W-1:0]      clr_o
);
  localparam int PAD_W = DATA_W - W;

  logic [W-1:0]      mask_q;
  logic              en_q;
  logic [DATA_W-1:0] rd_nxt, rd_q;
  logic              sel_ctrl, sel_mask, sel_masked, sel_raw;
  logic              unused_wd_hi;

  assign sel_ctrl   = (reg_addr == ADDR_W'(ADR_CTRL));
  assign sel_mask   = (reg_addr == ADDR_W'(ADR_MASK));
  assign sel_masked = (reg_addr == ADDR_W'(ADR_MASKED));
  assign sel_raw    = (reg_addr == ADDR_W'(ADR_RAW));

  assign unused_wd_hi = ^reg_wdata[DATA_W-1:W];

  always_ff @(posedge clk) begin
    if (rst) begin
      mask_q <= '0;
      en_q   <= 1'b0;
    end else if (reg_wr) begin
      if (sel_ctrl) en_q   <= reg_wdata[CTRL_EN_BIT];
      if (sel_mask) mask_q <= reg_wdata[W-1:0];
    end
  end

  assign clr_o = (reg_wr && sel_raw) ? reg_wdata[W-1:0] : '0;

  always_comb begin
    rd_nxt = '0;
    if (sel_ctrl)   rd_nxt[CTRL_EN_BIT] = en_q;
    if (sel_mask)   rd_nxt = {{PAD_W{1'b0}}, mask_q};
    if (sel_masked) rd_nxt = {{PAD_W{1'b0}}, masked_i};
    if (sel_raw)    rd_nxt = {{PAD_W{1'b0}}, flags_i};
  end

  always_ff @(posedge clk) begin
    if (rst) rd_q <= '0;
    else     rd_q <= rd_nxt;
  end

  assign reg_rdata = rd_q;
  assign mask_o    = mask_q;
  assign en_o      = en_q;
endmodule

// File: rtl/irq_hub.sv
module irq_hub
  import irq_pkg::*;
#(
  parameter int NUM_CARD_IRQ = 4,
  parameter int DATA_W       = 32,
  parameter int ADDR_W       = 2,
  localparam int STAT_W      = NUM_CORE_EVT + NUM_CARD_IRQ
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic              reg_wr,
  input  logic [DATA_W-1:0] reg_wdata,
  output logic [DATA_W-1:0] reg_rdata,
  input  logic [STAT_W-1:0] evt,
  output logic              irq,
  output logic              grp_cmd_err,
  output logic              grp_dat_err,
  output logic              grp_rd_end,
  output logic              grp_wr_end
);
  logic [STAT_W-1:0] raw_q, mask_q, masked, clr_vec;
  logic              glob_en;

  irq_raw_status #(.W(STAT_W)) u_raw (
    .clk(clk), .rst(rst), .set_i(evt), .clr_i(clr_vec), .flags_o(raw_q)
  );

  irq_gate #(.W(STAT_W)) u_gate (
    .clk(clk), .rst(rst), .flags_i(raw_q), .mask_i(mask_q), .en_i(glob_en),
    .masked_o(masked), .irq_o(irq)
  );

  irq_regfile #(.W(STAT_W), .DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_regs (
    .clk(clk), .rst(rst), .reg_addr(reg_addr), .reg_wr(reg_wr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .flags_i(raw_q),
    .masked_i(masked), .mask_o(mask_q), .en_o(glob_en), .clr_o(clr_vec)
  );

  assign grp_cmd_err = |(raw_q & STAT_W'(GRP_CMD_ERR));
  assign grp_dat_err = |(raw_q & STAT_W'(GRP_DAT_ERR));
  assign grp_rd_end  = |(raw_q & STAT_W'(GRP_RD_END));
  assign grp_wr_end  = |(raw_q & STAT_W'(GRP_WR_END));
endmodule

// File: rtl/irq_hub_chk.sv
module irq_hub_chk #(
  parameter int W = 20
) (
  input logic         clk,
  input logic         rst,
  input logic [W-1:0] evt,
  input logic [W-1:0] clr,
  input logic [W-1:0] raw,
  input logic         en,
  input logic         irq
);
  // R2 / R4: every pulsed flag is set at the next edge, clear or not
  a_r4_event_wins: assert property (@(posedge clk) disable iff (rst)
    (evt != '0) |=> ((raw & $past(evt)) == $past(evt)));

  // R3: flags named by a clearing write and not hit by an event go low
  a_r3_clear_works: assert property (@(posedge clk) disable iff (rst)
    ((clr & ~evt) != '0) |=> ((raw & $past(clr & ~evt)) == '0));

  // R6: the line never rises without the global enable in the prior cycle
  a_r6_irq_needs_en: assert property (@(posedge clk) disable iff (rst)
    $rose(irq) |-> $past(en));

  // R6: with the enable off the line is low one cycle later
  a_r6_disable_drops: assert property (@(posedge clk) disable iff (rst)
    !en |=> !irq);

  // R3: a flag that neither an event nor a clear touches holds its value
  a_r3_flags_hold: assert property (@(posedge clk) disable iff (rst)
    ((evt == '0) && (clr == '0)) |=> $stable(raw));
endmodule

bind irq_hub irq_hub_chk #(.W(STAT_W)) u_chk (
  .clk(clk), .rst(rst), .evt(evt), .clr(clr_vec), .raw(raw_q),
  .en(glob_en), .irq(irq)
);

// File: tb/sim_irq_hub.sv
module sim_irq_hub;
  localparam int SW = 20;
  localparam int DW = 32;
  localparam int AW = 2;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic [AW-1:0] reg_addr = '0;
  logic          reg_wr = 1'b0;
  logic [DW-1:0] reg_wdata = '0;
  logic [DW-1:0] reg_rdata;
  logic [SW-1:0] evt = '0;
  logic          irq, grp_cmd_err, grp_dat_err, grp_rd_end, grp_wr_end;

  int n_run = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;   // 250 MHz

  irq_hub u0 (
    .clk(clk), .rst(rst), .reg_addr(reg_addr), .reg_wr(reg_wr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .evt(evt), .irq(irq),
    .grp_cmd_err(grp_cmd_err), .grp_dat_err(grp_dat_err),
    .grp_rd_end(grp_rd_end), .grp_wr_end(grp_wr_end)
  );

  task automatic check(input string req, input logic [DW-1:0] act, input logic [DW-1:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(input int a, input logic [DW-1:0] d);
    @(negedge clk);
    reg_addr = AW'(a); reg_wdata = d; reg_wr = 1'b1;
    @(negedge clk);
    reg_wr = 1'b0; reg_wdata = '0;
  endtask

  task automatic rd(input int a, output logic [DW-1:0] d);
    @(negedge clk);
    reg_addr = AW'(a);
    @(negedge clk);
    d = reg_rdata;
  endtask

  task automatic pulse(input logic [SW-1:0] e);
    @(negedge clk);
    evt = e;
    @(negedge clk);
    evt = '0;
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin : stim
    logic [DW-1:0] v;
    logic [SW-1:0] exp_raw;
    repeat (3) @(negedge clk);
    rst = 1'b0;

    // R1: reset state, R9 addressed read one edge later
    check("R1 irq", DW'(irq), 0);
    for (int a = 0; a < 4; a++) begin
      rd(a, v);
      check("R1 reg", v, 0);
    end

    // R2 R3 R5 R6 R7 R8: sweep every flag position
    for (int i = 0; i < SW; i++) begin
      exp_raw = SW'(1) << i;
      pulse(exp_raw);
      check("R8 cmd", DW'(grp_cmd_err), DW'((32'h1142 >> i) & 1));
      check("R8 dat", DW'(grp_dat_err), DW'((32'hBA80 >> i) & 1));
      check("R8 rd",  DW'(grp_rd_end),  DW'((32'h0428 >> i) & 1));
      check("R8 wr",  DW'(grp_wr_end),  DW'((32'h0418 >> i) & 1));
      rd(3, v);
      check("R2 raw bit", v, DW'(exp_raw));
      check("R7 masked irq low", DW'(irq), 0);
      rd(2, v);
      check("R5 masked zero", v, 0);
      wr(1, DW'(exp_raw));
      wr(0, 32'h10);
      rd(2, v);
      check("R5 masked view", v, DW'(exp_raw));
      check("R6 irq high", DW'(irq), 1);
      wr(0, 32'h0);
      @(negedge clk);
      check("R6 irq off", DW'(irq), 0);
      wr(3, ~DW'(exp_raw));
      rd(3, v);
      check("R3 zeros keep", v, DW'(exp_raw));
      wr(3, DW'(exp_raw));
      rd(3, v);
      check("R3 one clears", v, 0);
      wr(1, 32'h0);
    end

    // R6: one-cycle lag from pending flag to line
    wr(1, 32'h4);
    wr(0, 32'h10);
    @(negedge clk);
    evt = 20'h4;
    @(negedge clk);
    evt = '0;
    check("R6 lag before", DW'(irq), 0);
    @(negedge clk);
    check("R6 lag after", DW'(irq), 1);
    wr(3, 32'hFFFF_FFFF);
    @(negedge clk);
    check("R6 drop after clear", DW'(irq), 0);
    wr(0, 32'h0);
    wr(1, 32'h0);

    // R4: event and clear on the same cycle
    pulse(20'hFFFFF);
    @(negedge clk);
    evt = 20'h8; reg_addr = AW'(3); reg_wdata = 32'hFFFF_FFFF; reg_wr = 1'b1;
    @(negedge clk);
    evt = '0; reg_wr = 1'b0;
    rd(3, v);
    check("R4 event wins", v, 32'h8);

    // R3: all ones clears everything
    pulse(20'hA5A5A);
    wr(3, 32'hFFFF_FFFF);
    rd(3, v);
    check("R3 all clear", v, 0);

    // R5 R6: upper bits read as zero, ctrl keeps bit 4 only
    wr(1, 32'hFFFF_FFFF);
    rd(1, v);
    check("R5 mask width", v, 32'h000F_FFFF);
    wr(2, 32'hFFFF_FFFF);
    rd(2, v);
    check("R5 masked write ignored", v, 0);
    wr(0, 32'hFFFF_FFFF);
    rd(0, v);
    check("R6 ctrl bits", v, 32'h10);
    @(negedge clk);
    check("R6 no pending", DW'(irq), 0);

    // R9: read data follows address after one edge
    wr(0, 32'h0);
    @(negedge clk);
    reg_addr = AW'(1);
    #1;
    check("R9 before edge", reg_rdata, 32'h0);
    @(negedge clk);
    check("R9 after edge", reg_rdata, 32'h000F_FFFF);

    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule